// File: doc/BRIEF.md
# Constant On/Off-Time Switching Modulator

This block is the digital timing core of a variable-frequency, current-mode buck controller. An analog comparator outside the block reports when the sensed inductor current has reached the control level. That report enters the block as an asynchronous flag. The block resynchronises the flag and turns each new crossing into a single event. The event starts a one-shot timer. No fixed clock sets the switching period: the timer length and the moment of the next crossing set it together.

One mode input selects between two polarities. In constant off-time operation, a crossing removes the high-side request for a programmed number of system clocks, and the request returns when the timer runs out. In constant on-time operation, a crossing raises the high-side request for the programmed time, and the request drops when the timer expires. A non-overlap stage converts the request into complementary high-side and low-side gate signals. It inserts a programmable gap on every transition. It also emits a one-cycle marker on each rising and each falling edge of the high-side gate, for downstream sampling logic. At the nominal rate, about 203 clocks of 10 ns give the constant time used with a 200 kHz switching target.

Top module: `cotm_top`

## Requirements
- R1: While `rst_n` is low, `gate_hi`, `gate_lo`, `hs_rise` and `hs_fall` are all 0.
- R2: `cmp_in` passes through a two-flop synchroniser, and only a 0-to-1 transition counts as a crossing. A held high level starts nothing further. A rise first captured at clock edge k can change the gates no earlier than edge k+3.
- R3: With `mode_on`=0 (constant off-time), the high-side request is high while the timer is idle. A crossing drops the request for T = `t_const` clocks. When T >= D+2, where D = `t_dead`, `gate_hi` stays low for T+D+1 cycles per crossing.
- R4: With `mode_on`=1 (constant on-time), the high-side request is low while idle. A crossing raises the request for T clocks. When T >= D+2, `gate_hi` stays high for T-D-1 cycles per crossing.
- R5: `gate_hi` and `gate_lo` are never high in the same cycle.
- R6: On every handover between the gates, both gates are low for D+1 cycles.
- R7: A crossing that arrives while the timer is running is ignored. This includes a crossing in the timer's last cycle. A crossing one cycle after expiry starts a new period.
- R8: `t_const` is sampled only when the timer starts. A change during a count affects only the next period. A value of 0 acts as 1.
- R9: `hs_rise` is high for exactly the first cycle in which `gate_hi` is high. `hs_fall` is high for exactly the first cycle in which `gate_hi` is low after being high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cmp_in | input | 1 | Asynchronous current-crossing flag from the comparator |
| mode_on | input | 1 | 0 = constant off-time, 1 = constant on-time |
| t_const | input | TIME_W (16) | Constant-time length in clocks |
| t_dead | input | DEAD_W (8) | Non-overlap length D; the gap is D+1 clocks |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| hs_rise | output | 1 | One-cycle marker of a `gate_hi` rising edge |
| hs_fall | output | 1 | One-cycle marker of a `gate_hi` falling edge |

## Verification
A crossing event and the timer's expiry can fall in the same cycle. The bench provokes this by placing a second comparator rise exactly T clocks after the first, which puts the second event in the timer's final count. It judges the result by counting `gate_hi` rising edges: one rise shows that the event was dropped. It then repeats the test with the second rise one clock later. There the event lands just after expiry, so it must start a fresh period, and two rises are expected.

// File: rtl/cotm_pkg.sv
`timescale 1ns/1ps
package cotm_pkg;

  // Operating polarity selected by the mode input
  typedef enum logic {
    MODE_OFFTIME = 1'b0,
    MODE_ONTIME  = 1'b1
  } mod_mode_t;

  // Non-overlap stage: both off (counting), low side on, high side on
  typedef enum logic [1:0] {
    DT_GAP = 2'd0,
    DT_LO  = 2'd1,
    DT_HI  = 2'd2
  } dt_state_t;

endpackage

// File: rtl/cotm_sync.sv
`timescale 1ns/1ps
module cotm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_evt
);
  // STAGES flops of synchroniser plus one history flop for edge detection
  localparam int LEN = STAGES + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LEN-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_evt = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/cotm_oneshot.sv
`timescale 1ns/1ps
module cotm_oneshot #(
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TIME_W-1:0] load_val,
  output logic              running,
  output logic              done,
  output logic [TIME_W-1:0] count
);
  localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

  logic              run_q, run_d;
  logic [TIME_W-1:0] cnt_q, cnt_d;
  logic [TIME_W-1:0] load_eff;

  // A zero length behaves as a single clock
  assign load_eff = (load_val == '0) ? ONE : load_val;
  assign done     = run_q && (cnt_q == ONE);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = load_eff;
    end else if (done) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign running = run_q;
  assign count   = cnt_q;
endmodule

// File: rtl/cotm_seq.sv
`timescale 1ns/1ps
module cotm_seq
  import cotm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic mode_on,
  input  logic running,
  input  logic done,
  output logic start,
  output logic hs_req
);
  mod_mode_t mode;
  logic      idle_level;
  logic      req_q, req_d;

  assign mode       = mod_mode_t'(mode_on);
  // Request level outside a timed interval: on in off-time mode
  assign idle_level = (mode == MODE_OFFTIME);
  // Crossings are accepted only when the timer is idle
  assign start      = evt && !running;

  always_comb begin
    if (start)                req_d = ~idle_level;
    else if (running && !done) req_d = req_q;
    else                      req_d = idle_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign hs_req = req_q;
endmodule

// File: rtl/cotm_deadtime.sv
`timescale 1ns/1ps
module cotm_deadtime
  import cotm_pkg::*;
#(
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [DEAD_W-1:0] dead,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              rise_pulse,
  output logic              fall_pulse
);
  dt_state_t         st_q, st_d;
  logic [DEAD_W-1:0] cnt_q, cnt_d;
  logic              hi_hist_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      DT_LO: if (req) begin
        st_d  = DT_GAP;
        cnt_d = dead;
      end
      DT_HI: if (!req) begin
        st_d  = DT_GAP;
        cnt_d = dead;
      end
      DT_GAP: begin
        if (cnt_q != '0) cnt_d = cnt_q - DEAD_W'(1);
        else             st_d  = req ? DT_HI : DT_LO;
      end
      default: begin
        st_d  = DT_GAP;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= DT_GAP;
      cnt_q     <= '0;
      hi_hist_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      hi_hist_q <= gate_hi;
    end
  end

  assign gate_hi    = (st_q == DT_HI);
  assign gate_lo    = (st_q == DT_LO);
  assign rise_pulse = gate_hi & ~hi_hist_q;
  assign fall_pulse = ~gate_hi & hi_hist_q;
endmodule

// File: rtl/cotm_top.sv
`timescale 1ns/1ps
module cotm_top #(
  parameter int TIME_W      = 16,
  parameter int DEAD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_in,
  input  logic              mode_on,
  input  logic [TIME_W-1:0] t_const,
  input  logic [DEAD_W-1:0] t_dead,
  output logic              gate_hi,
  output logic              gate_lo,
  output logic              hs_rise,
  output logic              hs_fall
);
  logic              evt_w;
  logic              start_w;
  logic              run_w;
  logic              done_w;
  logic [TIME_W-1:0] cnt_w;
  logic              req_w;

  cotm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_in),
    .rise_evt (evt_w)
  );

  cotm_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (evt_w),
    .mode_on (mode_on),
    .running (run_w),
    .done    (done_w),
    .start   (start_w),
    .hs_req  (req_w)
  );

  cotm_oneshot #(.TIME_W(TIME_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .load_val (t_const),
    .running  (run_w),
    .done     (done_w),
    .count    (cnt_w)
  );

  cotm_deadtime #(.DEAD_W(DEAD_W)) u_dead (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req_w),
    .dead       (t_dead),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .rise_pulse (hs_rise),
    .fall_pulse (hs_fall)
  );
endmodule

// File: rtl/cotm_checker.sv
`timescale 1ns/1ps
module cotm_checker #(
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_hi,
  input logic              gate_lo,
  input logic              hs_rise,
  input logic              hs_fall,
  input logic              hs_req,
  input logic              running,
  input logic              done,
  input logic [TIME_W-1:0] cnt
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R5

  AST_GAP_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> $past(!gate_lo)); // R6

  AST_GAP_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> $past(!gate_hi)); // R6

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !done) |=> $stable(hs_req)); // R7

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !done) |=> (running && (cnt == $past(cnt) - TIME_W'(1)))); // R8

  AST_RISE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> hs_rise); // R9

  AST_RISE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_rise |=> !hs_rise); // R9

  AST_FALL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fall |=> !hs_fall); // R9
endmodule

bind cotm_top cotm_checker #(.TIME_W(TIME_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .gate_hi (gate_hi),
  .gate_lo (gate_lo),
  .hs_rise (hs_rise),
  .hs_fall (hs_fall),
  .hs_req  (req_w),
  .running (run_w),
  .done    (done_w),
  .cnt     (cnt_w)
);

// File: tb/cotm_top_test.sv
`timescale 1ns/1ps
module cotm_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_in;
  logic        mode_on;
  logic [15:0] t_const;
  logic [7:0]  t_dead;
  logic        gate_hi, gate_lo, hs_rise, hs_fall;

  int checks = 0;
  int fails  = 0;

  // Monitor results
  int overlaps = 0, pulse_err = 0, rises = 0, falls = 0;
  int rise_pulses = 0;
  int hi_run = 0, lo_run = 0, gap_run = 0;
  int last_hi = 0, last_lo = 0, last_gap = 0;
  logic prev_gh = 1'b0;

  always #5 clk = ~clk;

  cotm_top uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .mode_on(mode_on),
    .t_const(t_const), .t_dead(t_dead),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .hs_rise(hs_rise), .hs_fall(hs_fall)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_gh = 1'b0; hi_run = 0; lo_run = 0; gap_run = 0;
    end else begin
      if (gate_hi && gate_lo) overlaps++;
      if (hs_rise) rise_pulses++;
      if (hs_rise != (gate_hi && !prev_gh)) pulse_err++;
      if (hs_fall != (!gate_hi && prev_gh)) pulse_err++;
      if (gate_hi && !prev_gh) begin rises++; last_lo = lo_run; end
      if (!gate_hi && prev_gh) begin falls++; last_hi = hi_run; end
      hi_run = gate_hi ? hi_run + 1 : 0;
      lo_run = gate_hi ? 0 : lo_run + 1;
      if (!gate_hi && !gate_lo) gap_run++;
      else begin
        if (gap_run > 0) last_gap = gap_run;
        gap_run = 0;
      end
      prev_gh = gate_hi;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulse_cmp(input int hold);
    cmp_in = 1'b1;
    step(hold);
    cmp_in = 1'b0;
  endtask

  task automatic setup(input logic m, input int t, input int d);
    mode_on = m; t_const = 16'(t); t_dead = 8'(d);
    step(60);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmp_in = 1'b0; mode_on = 1'b0; t_const = 16'd20; t_dead = 8'd3;
    step(4);
    chk(gate_hi == 1'b0, "R1 gate_hi in reset", int'(gate_hi), 0);
    chk(gate_lo == 1'b0, "R1 gate_lo in reset", int'(gate_lo), 0);
    chk(hs_rise == 1'b0, "R1 hs_rise in reset", int'(hs_rise), 0);
    chk(hs_fall == 1'b0, "R1 hs_fall in reset", int'(hs_fall), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_on_basic();
    int r0;
    setup(1'b1, 20, 3);
    chk(gate_lo == 1'b1 && gate_hi == 1'b0, "R4 idle low side on", int'(gate_lo), 1);
    r0 = rises;
    cmp_in = 1'b1;
    step(3);
    chk(gate_lo == 1'b1, "R2 no change before edge k+3", int'(gate_lo), 1);
    step(1);
    chk(gate_lo == 1'b0, "R2 low side off at edge k+3", int'(gate_lo), 0);
    step(30);           // held high: level must not retrigger
    cmp_in = 1'b0;
    step(40);
    chk(rises - r0 == 1, "R2 held level gives one period", rises - r0, 1);
    chk(last_hi == 16, "R4 high width T-D-1", last_hi, 16);
    chk(last_gap == 4, "R6 gap D+1 on return", last_gap, 4);
  endtask

  task automatic t_ignore_busy();
    int r0;
    setup(1'b1, 20, 3);
    r0 = rises;
    pulse_cmp(2);
    step(6);
    pulse_cmp(2);       // lands while the timer runs
    step(60);
    chk(rises - r0 == 1, "R7 busy crossing ignored", rises - r0, 1);
    chk(last_hi == 16, "R7 width unchanged", last_hi, 16);
  endtask

  task automatic t_coincide(input int extra, input int exp_rises);
    int r0;
    setup(1'b1, 10, 1);
    r0 = rises;
    pulse_cmp(2);
    step(10 - 2 + extra);
    pulse_cmp(2);
    step(60);
    chk(rises - r0 == exp_rises,
        extra == 0 ? "R7 crossing in expiry cycle ignored" : "R7 crossing after expiry accepted",
        rises - r0, exp_rises);
  endtask

  task automatic t_load();
    setup(1'b1, 40, 3);
    pulse_cmp(2);
    step(10);
    t_const = 16'd5;    // mid-count change
    step(60);
    chk(last_hi == 36, "R8 value held during count", last_hi, 36);
    pulse_cmp(2);
    step(40);
    chk(last_hi == 1, "R8 new value on next start", last_hi, 1);
  endtask

  task automatic t_off();
    int f0;
    setup(1'b0, 30, 2);
    chk(gate_hi == 1'b1 && gate_lo == 1'b0, "R3 idle high side on", int'(gate_hi), 1);
    f0 = falls;
    pulse_cmp(2);
    step(80);
    chk(falls - f0 == 1, "R3 one off interval", falls - f0, 1);
    chk(last_lo == 33, "R3 low span T+D+1", last_lo, 33);
    chk(last_gap == 3, "R6 gap D+1 in off-time mode", last_gap, 3);
  endtask

  task automatic t_zero();
    setup(1'b0, 0, 0);
    pulse_cmp(2);
    step(30);
    chk(last_lo == 1, "R8 zero acts as one", last_lo, 1);
    chk(gate_hi == 1'b1, "R8 high side back on", int'(gate_hi), 1);
  endtask

  task automatic t_dead_sweep(input int d);
    setup(1'b1, 20, d);
    pulse_cmp(2);
    step(60);
    chk(last_gap == d + 1, "R6 gap tracks t_dead", last_gap, d + 1);
    chk(last_hi == 20 - d - 1, "R4 width tracks t_dead", last_hi, 20 - d - 1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_on_basic();
    t_ignore_busy();
    t_coincide(0, 1);
    t_coincide(1, 2);
    t_load();
    t_off();
    t_zero();
    t_dead_sweep(0);
    t_dead_sweep(7);
    chk(overlaps == 0, "R5 no overlap", overlaps, 0);
    chk(pulse_err == 0, "R9 edge markers match gate edges", pulse_err, 0);
    chk(rise_pulses == rises, "R9 one marker per rise", rise_pulses, rises);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule